// File: doc/BRIEF.md
# Timer Counter Channel with Interval, Overflow and Triple Match Events

This block is a single counting channel with a register port. Each cycle that the count-enable input is high, the counter advances by one. In overflow mode it rolls over from all-ones to zero. In interval mode it returns to zero after it has sat at a programmed interval value. Three match comparators watch the count. All five event sources set sticky bits in a status register. An enable register selects which pending bits drive the single interrupt line.

Software configures the channel through a flat register port. It restarts the count by writing a self-clearing bit in the control register. It services the interrupt by reading the status register. That read returns the pending bits and clears them. An event that arrives in the same cycle as the read is kept pending for the next read.

Top module: `tmr_chan`

## Requirements
- R1: After reset the count, status, enable, interval, match and control registers are all zero and `irq` is low.
- R2: With control bit 0 clear (overflow mode), each cycle with `cnt_en` high adds one to the count. A count of all-ones becomes zero instead and sets status bit 4.
- R3: With control bit 0 set (interval mode), a `cnt_en` cycle whose count equals the interval register (address 1) returns the count to zero and sets status bit 0. A count above the interval still rolls over at all-ones, as in R2.
- R4: A `cnt_en` cycle whose count equals match register k (addresses 2, 3, 4 for k = 1, 2, 3) sets status bit k.
- R5: While `cnt_en` is low, the count holds and no status bit is set.
- R6: Writing control (address 0) with bit 1 set forces the count to zero on that edge and suppresses every event of that cycle. Control bit 1 then reads as 1 for exactly one cycle and clears itself.
- R7: Reading the status register (address 6, bits 4..0) returns the pending bits and clears them on the same edge. A bit raised by an event in that same cycle is still set afterwards.
- R8: Writes to the status register (address 6) and to the count readback (address 7) have no effect.
- R9: `irq` is high exactly when some status bit is set whose bit in the enable register (address 5, same bit positions as the status register) is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (only matters for status) |
| reg_addr | input | 3 | Register address: 0 control, 1 interval, 2-4 match 1-3, 5 enable, 6 status, 7 count |
| reg_wdata | input | CW | Write data |
| reg_rdata | output | CW | Read data for `reg_addr`, combinational |
| cnt_en | input | 1 | Count clock enable, one increment per high cycle |
| irq | output | 1 | Channel interrupt |

## Verification
The assertions check the following on every cycle:
- the count stays put while there is no enable and no restart;
- restart forces zero, and its flag clears itself;
- interval and all-ones rollover each set their status bit on the next edge;
- pending bits stay set until a status read;
- a read with no counting leaves status empty;
- `irq` stays quiet while every enable is clear.

Only the bench scenarios can show the following:
- the exact count sequence across every interval value;
- which match bit appears on which tick;
- how the enable mask combines with each status pattern;
- that a read colliding with an event keeps the new bit;
- that writes to read-only addresses leave the state untouched.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
    localparam int NUM_MATCH = 3;
    localparam int NUM_EV    = 5;

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_IVL  = 3'd1,
        A_M1   = 3'd2,
        A_M2   = 3'd3,
        A_M3   = 3'd4,
        A_IEN  = 3'd5,
        A_STS  = 3'd6,
        A_CNT  = 3'd7
    } addr_e;

    localparam int CTRL_MODE = 0;   // 1 = interval mode
    localparam int CTRL_RST  = 1;   // self-clearing restart
    localparam int EV_IVL    = 0;
    localparam int EV_M1     = 1;   // match k at bit k
    localparam int EV_OVF    = 4;
endpackage

// File: rtl/tmr_chan_counter.sv
module tmr_chan_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          restart,
    input  logic          ivl_mode,
    input  logic [CW-1:0] ivl_val,
    output logic [CW-1:0] count,
    output logic          ivl_ev,
    output logic          ovf_ev
);
    localparam logic [CW-1:0] TOP = '1;

    logic [CW-1:0] count_d, count_q;
    logic          ivl_hit, top_hit;

    always_comb begin
        ivl_hit = ivl_mode && (count_q == ivl_val);
        top_hit = !ivl_hit && (count_q == TOP);
        count_d = count_q;
        ivl_ev  = 1'b0;
        ovf_ev  = 1'b0;
        if (restart) begin
            count_d = '0;
        end else if (tick) begin
            if (ivl_hit) begin
                count_d = '0;
                ivl_ev  = 1'b1;
            end else if (top_hit) begin
                count_d = '0;
                ovf_ev  = 1'b1;
            end else begin
                count_d = count_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/tmr_chan_match.sv
module tmr_chan_match #(
    parameter int CW = 16
) (
    input  logic          tick,
    input  logic          restart,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] mval,
    output logic          hit
);
    always_comb hit = tick && !restart && (count == mval);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int CW = 16   // at least 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic          reg_re,
    input  logic [2:0]    reg_addr,
    input  logic [CW-1:0] reg_wdata,
    output logic [CW-1:0] reg_rdata,
    input  logic          cnt_en,
    output logic          irq
);
    typedef struct packed {
        logic                          mode;
        logic                          restart;
        logic [CW-1:0]                 ivl;
        logic [NUM_MATCH-1:0][CW-1:0]  mt;
        logic [NUM_EV-1:0]             ien;
        logic [NUM_EV-1:0]             sts;
    } state_t;

    state_t st_d, st_q;

    logic                 wr_rst;
    logic                 sts_rd;
    logic [CW-1:0]        count;
    logic                 ivl_ev, ovf_ev;
    logic [NUM_MATCH-1:0] m_hit;
    logic [NUM_EV-1:0]    ev;

    // views for the bound checker
    logic [NUM_EV-1:0]    sts_w, ien_w;
    logic [CW-1:0]        ivl_w;
    logic                 mode_w, rstf_w;

    assign wr_rst = reg_we && (reg_addr == A_CTRL) && reg_wdata[CTRL_RST];
    assign sts_rd = reg_re && (reg_addr == A_STS);

    tmr_chan_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (cnt_en),
        .restart  (wr_rst),
        .ivl_mode (st_q.mode),
        .ivl_val  (st_q.ivl),
        .count    (count),
        .ivl_ev   (ivl_ev),
        .ovf_ev   (ovf_ev)
    );

    for (genvar k = 0; k < NUM_MATCH; k++) begin : g_match
        tmr_chan_match #(.CW(CW)) u_m (
            .tick    (cnt_en),
            .restart (wr_rst),
            .count   (count),
            .mval    (st_q.mt[k]),
            .hit     (m_hit[k])
        );
    end

    assign ev = {ovf_ev, m_hit, ivl_ev};

    always_comb begin
        st_d         = st_q;
        st_d.restart = wr_rst;
        if (reg_we) begin
            case (reg_addr)
                A_CTRL: st_d.mode  = reg_wdata[CTRL_MODE];
                A_IVL:  st_d.ivl   = reg_wdata;
                A_M1:   st_d.mt[0] = reg_wdata;
                A_M2:   st_d.mt[1] = reg_wdata;
                A_M3:   st_d.mt[2] = reg_wdata;
                A_IEN:  st_d.ien   = reg_wdata[NUM_EV-1:0];
                default: ;
            endcase
        end
        st_d.sts = (sts_rd ? '0 : st_q.sts) | ev;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[CTRL_MODE] = st_q.mode;
                reg_rdata[CTRL_RST]  = st_q.restart;
            end
            A_IVL:  reg_rdata = st_q.ivl;
            A_M1:   reg_rdata = st_q.mt[0];
            A_M2:   reg_rdata = st_q.mt[1];
            A_M3:   reg_rdata = st_q.mt[2];
            A_IEN:  reg_rdata[NUM_EV-1:0] = st_q.ien;
            A_STS:  reg_rdata[NUM_EV-1:0] = st_q.sts;
            default: reg_rdata = count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq    = |(st_q.sts & st_q.ien);
    assign sts_w  = st_q.sts;
    assign ien_w  = st_q.ien;
    assign ivl_w  = st_q.ivl;
    assign mode_w = st_q.mode;
    assign rstf_w = st_q.restart;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
    import tmr_chan_pkg::*;
#(
    parameter int CW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic              reg_re,
    input logic [2:0]        reg_addr,
    input logic [CW-1:0]     reg_wdata,
    input logic              cnt_en,
    input logic              irq,
    input logic [CW-1:0]     count,
    input logic [NUM_EV-1:0] sts,
    input logic [NUM_EV-1:0] ien,
    input logic [CW-1:0]     ivl,
    input logic              mode,
    input logic              rstf
);
    logic wr_r, rd_s;
    assign wr_r = reg_we && (reg_addr == A_CTRL) && reg_wdata[CTRL_RST];
    assign rd_s = reg_re && (reg_addr == A_STS);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (count == '0 && sts == '0 && ien == '0 && !irq));

    a_r2_rollover: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !mode && count == {CW{1'b1}} && !wr_r) |=> (count == '0 && sts[EV_OVF]));

    a_r3_interval_end: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && mode && count == ivl && !wr_r) |=> (count == '0 && sts[EV_IVL]));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !wr_r) |=> $stable(count));

    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        wr_r |=> (count == '0 && rstf));

    a_r6_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rstf && !wr_r) |=> !rstf);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_s |=> ((sts & $past(sts)) == $past(sts)));

    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_s && !cnt_en) |=> (sts == '0));

    a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);
endmodule

bind tmr_chan tmr_chan_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cnt_en    (cnt_en),
    .irq       (irq),
    .count     (count),
    .sts       (sts_w),
    .ien       (ien_w),
    .ivl       (ivl_w),
    .mode      (mode_w),
    .rstf      (rstf_w)
);

// File: tb/sim_tmr_chan.sv
`timescale 1ns/1ps
module sim_tmr_chan;
    localparam int CW  = 5;
    localparam int TOP = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0, reg_re = 1'b0, cnt_en = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [CW-1:0] reg_wdata = '0;
    logic [CW-1:0] reg_rdata;
    logic          irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tmr_chan #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cnt_en(cnt_en), .irq(irq)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int a, int d, bit tk);
        reg_we = 1'b1; reg_addr = a[2:0]; reg_wdata = d[CW-1:0]; cnt_en = tk;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0; cnt_en = 1'b0;
    endtask

    task automatic rd(int a, bit tk, output int v);
        reg_re = 1'b1; reg_addr = a[2:0]; cnt_en = tk;
        #1 v = int'(reg_rdata);
        @(posedge clk); @(negedge clk);
        reg_re = 1'b0; cnt_en = 1'b0;
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            cnt_en = 1'b1;
            @(posedge clk); @(negedge clk);
            cnt_en = 1'b0;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=0 exp=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int v, exp;
        idle(2);
        #2;
        chk("R1 irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(7, 0, v); chk("R1 count", v, 0);
        rd(6, 0, v); chk("R1 status", v, 0);
        rd(0, 0, v); chk("R1 ctrl", v, 0);
        rd(5, 0, v); chk("R1 enable", v, 0);
        rd(1, 0, v); chk("R1 interval", v, 0);
        rd(2, 0, v); chk("R1 match1", v, 0);

        // R6: restart flag visible for one cycle only
        wr(0, 2, 0);
        rd(0, 0, v); chk("R6 flag set", v, 2);
        rd(0, 0, v); chk("R6 flag cleared", v, 0);

        // R2: overflow-mode count sweep with two rollovers
        for (int t = 1; t <= 70; t++) begin
            tick(1);
            rd(7, 0, v); chk("R2 count", v, t % (TOP + 1));
        end
        rd(6, 0, v); chk("R2 R4 status after rollovers", v, 5'h1E);
        rd(6, 0, v); chk("R7 status cleared", v, 0);

        // R3: interval sweep over every interval value
        wr(2, TOP, 0); wr(3, TOP, 0); wr(4, TOP, 0);
        for (int iv = 0; iv <= TOP; iv++) begin
            wr(1, iv, 0);
            wr(0, 3, 0);
            rd(6, 0, v);
            for (int t = 1; t <= 2 * (iv + 1) + 1; t++) begin
                tick(1);
                rd(7, 0, v); chk("R3 count", v, t % (iv + 1));
            end
            exp = 1 | ((iv == TOP) ? 5'h0E : 0);
            rd(6, 0, v); chk("R3 status", v, exp);
        end

        // R4: distinct match values, status read each tick
        wr(2, 3, 0); wr(3, 7, 0); wr(4, 12, 0);
        wr(0, 2, 0);
        rd(6, 0, v);
        for (int t = 1; t <= TOP + 1; t++) begin
            tick(1);
            exp = (int'(t - 1 == 3) << 1) | (int'(t - 1 == 7) << 2) |
                  (int'(t - 1 == 12) << 3) | (int'(t == TOP + 1) << 4);
            rd(6, 0, v); chk("R4 per-tick status", v, exp);
        end

        // R9: enable mask sweep over two status patterns
        wr(2, 0, 0); wr(3, 0, 0); wr(4, 0, 0);
        wr(0, 2, 0);
        rd(6, 0, v);
        tick(TOP + 1);
        for (int e = 0; e < 32; e++) begin
            wr(5, e, 0);
            chk("R9 irq pattern 1E", int'(irq), int'((e & 5'h1E) != 0));
        end
        wr(1, 0, 0);
        wr(0, 3, 0);
        tick(1);
        for (int e = 0; e < 32; e++) begin
            wr(5, e, 0);
            chk("R9 irq pattern 1F", int'(irq), int'(e != 0));
        end
        rd(6, 0, v); chk("R7 read value", v, 5'h1F);
        chk("R9 irq after clear", int'(irq), 0);

        // R5: count holds without enable
        wr(0, 0, 0);
        tick(3);
        idle(5);
        rd(7, 0, v); chk("R5 count held", v, 3);
        rd(6, 0, v);
        idle(4);
        rd(6, 0, v); chk("R5 no events", v, 0);

        // R7: event colliding with a status read stays pending
        wr(2, 5, 0); wr(3, 9, 0); wr(4, 9, 0);
        wr(0, 2, 0);
        tick(5);
        rd(6, 0, v); chk("R7 nothing pending", v, 0);
        rd(6, 1, v); chk("R7 read during event", v, 0);
        rd(6, 0, v); chk("R7 collided event kept", v, 2);

        // R8: read-only addresses ignore writes
        wr(6, 31, 0);
        rd(6, 0, v); chk("R8 status write ignored", v, 0);
        wr(7, 20, 0);
        rd(7, 0, v); chk("R8 count write ignored", v, 6);

        // R6: restart with a same-cycle match suppresses the event
        wr(2, 6, 0);
        wr(0, 2, 1);
        rd(7, 0, v); chk("R6 count zero", v, 0);
        rd(6, 0, v); chk("R6 event suppressed", v, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule